// File: doc/BRIEF.md
# Configuration Register Bank with Cross-Clock Mailbox

This block holds the programmable settings that sit beside a dual-clock FIFO: a retransmit start pointer, a retransmit distance, the thresholds for the almost-full and almost-empty flags, a parity setting and a control word whose upper bits pick the timing mode of the half-full and almost-full flags. The bank lives in the input (write) clock domain and drives its settings out as plain signals to the flag and pointer logic.

The input port writes any setting with one strobe, a 3-bit selector and a 36-bit word. The output port reads every setting through a registered read path. It can also write the four pointer and threshold settings. Its writes are carried into the input domain by a toggle handshake. The read path delivers a value only while the FIFO array read path and the bypass path are both off.

A one-word mailbox passes a 36-bit word from the input side to the output side. Its full flag is active low and belongs to the input clock. A toggle that has passed through two flops clears the flag once the output side has read the word. No FIFO enable takes part in any of this.

Top module: `cfgmb_top`

## Requirements
- R1: After reset the selectors read: 0 retransmit base = 0, 1 retransmit distance = 0, 2 almost-full threshold = 8, 3 parity setting = 0, 4 almost-empty threshold = 8, 5 control word = 1, 6 mailbox = 0.
- R2: A read strobe on `out_rd` with a selector from 0 to 6 sets `rd_valid` and puts the addressed value, zero-extended to 36 bits, on `rd_data` at the next `out_clk` edge. Pointer and threshold fields are 10 bits, parity 4 bits and control 8 bits.
- R3: A read is refused when `fifo_path_on` or `bypass_on` is high, or when the selector is 7. A refused read gives `rd_valid` = 0 and `rd_data` = 0 at the next edge.
- R4: An input-port write with a selector from 0 to 5 stores the low bits of `in_data` at that `in_clk` edge. A write with selector 7 changes no setting.
- R5: `af_sync_mode` equals control bit 5 and `hf_mode` equals control bits [4:3].
- R6: An input-port write to selector 6 while the mailbox is empty stores the word and drives `mb_full_n` low at that `in_clk` edge.
- R7: An input-port write to selector 6 while `mb_full_n` is low leaves the stored mail word unchanged.
- R8: `mb_ready` rises in the output domain once mail is present. A read of selector 6 while `mb_ready` is high returns the word, and `mb_full_n` returns high within a few `in_clk` edges. A mailbox read while `mb_ready` is low does not change `mb_full_n`.
- R9: An output-port write to selector 0, 1, 2 or 4 is applied to the setting within a few `in_clk` edges. An output-port write to selector 3, 5, 6 or 7 has no effect.
- R10: An output-port write issued while an earlier one has not yet been acknowledged is dropped.
- R11: If an input-port write and an arriving output-port write address the same setting in one `in_clk` cycle, the input-port value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Input-side clock |
| out_clk | input | 1 | Output-side clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| in_wr | input | 1 | Input-port register write strobe |
| in_addr | input | 3 | Input-port selector |
| in_data | input | 36 | Input-port write data |
| out_rd | input | 1 | Output-port register read strobe |
| out_wr | input | 1 | Output-port register write strobe |
| out_addr | input | 3 | Output-port selector |
| out_wdata | input | 36 | Output-port write data |
| fifo_path_on | input | 1 | FIFO array read path is selected; refuses register reads |
| bypass_on | input | 1 | Bypass path is active; refuses register reads |
| rd_valid | output | 1 | Read result valid (out_clk) |
| rd_data | output | 36 | Read result, zero-extended (out_clk) |
| mb_full_n | output | 1 | Mailbox full, active low (in_clk) |
| mb_ready | output | 1 | Mail waiting for the output side (out_clk) |
| rt_base | output | 10 | Retransmit base setting |
| rt_offs | output | 10 | Retransmit distance setting |
| af_ofs | output | 10 | Almost-full threshold |
| ae_ofs | output | 10 | Almost-empty threshold |
| parity_cfg | output | 4 | Parity setting |
| af_sync_mode | output | 1 | Almost-full timing mode (control bit 5) |
| hf_mode | output | 2 | Half-full timing mode (control bits 4:3) |

## Verification
Read results are due at the first `out_clk` edge after the strobe. The scoreboard queues each expected word when the strobe is driven, and the monitor pops it on the falling edge that follows. Input-port writes and the mailbox full flag are due at the `in_clk` edge that takes the write, so they are sampled on the next falling edge. Results that cross domains, such as output-port writes, the mail-ready flag and the clearing of the full flag, arrive after two synchronizer flops plus one register. The bench polls for these within a bounded number of cycles. The conflict case is checked on every `in_clk` cycle while the input write is held, so the losing value never shows for even one cycle.

// File: rtl/cfgmb_pkg.sv
package cfgmb_pkg;

    localparam int DATA_W = 36;
    localparam int PTR_W  = 10;
    localparam int PAR_W  = 4;
    localparam int CTRL_W = 8;
    localparam int SEL_W  = 3;
    localparam int SYNC_STAGES = 2;

    localparam int AF_MODE_BIT = 5;
    localparam int HF_MODE_LSB = 3;

    localparam logic [PTR_W-1:0]  THR_RST  = PTR_W'(8);
    localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1);

    typedef enum logic [SEL_W-1:0] {
        SEL_RT_BASE = 3'd0,
        SEL_RT_OFFS = 3'd1,
        SEL_AF_THR  = 3'd2,
        SEL_PARITY  = 3'd3,
        SEL_AE_THR  = 3'd4,
        SEL_CTRL    = 3'd5,
        SEL_MAIL    = 3'd6,
        SEL_NONE    = 3'd7
    } sel_e;

    typedef struct packed {
        logic [PTR_W-1:0]  rt_base;
        logic [PTR_W-1:0]  rt_offs;
        logic [PTR_W-1:0]  af_thr;
        logic [PTR_W-1:0]  ae_thr;
        logic [PAR_W-1:0]  parity;
        logic [CTRL_W-1:0] ctrl;
    } cfg_t;

    typedef struct packed {
        sel_e              sel;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    localparam cfg_t CFG_RST = '{
        rt_base: '0, rt_offs: '0, af_thr: THR_RST,
        ae_thr: THR_RST, parity: '0, ctrl: CTRL_RST
    };

    function automatic logic out_writable(sel_e s);
        return (s == SEL_RT_BASE) || (s == SEL_RT_OFFS) ||
               (s == SEL_AF_THR)  || (s == SEL_AE_THR);
    endfunction

    function automatic cfg_t cfg_put(cfg_t c, sel_e s, logic [DATA_W-1:0] d);
        cfg_t r;
        r = c;
        case (s)
            SEL_RT_BASE: r.rt_base = d[PTR_W-1:0];
            SEL_RT_OFFS: r.rt_offs = d[PTR_W-1:0];
            SEL_AF_THR:  r.af_thr  = d[PTR_W-1:0];
            SEL_PARITY:  r.parity  = d[PAR_W-1:0];
            SEL_AE_THR:  r.ae_thr  = d[PTR_W-1:0];
            SEL_CTRL:    r.ctrl    = d[CTRL_W-1:0];
            default:     r = c;
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] widen_ptr(logic [PTR_W-1:0] v);
        return {{(DATA_W-PTR_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/cfgmb_sync.sv
module cfgmb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgmb_xwrite.sv
module cfgmb_xwrite
    import cfgmb_pkg::*;
(
    input  logic    in_clk,
    input  logic    out_clk,
    input  logic    rst,
    input  logic    out_wr,
    input  wr_req_t out_req,
    output logic    apply,
    output wr_req_t apply_req
);
    logic    req_tog, ack_s, req_s, seen;
    wr_req_t hold;
    logic    busy;

    assign busy = req_tog ^ ack_s;

    always_ff @(posedge out_clk) begin
        if (rst) begin
            req_tog <= 1'b0;
            hold    <= '{sel: SEL_NONE, data: '0};
        end else if (out_wr && !busy && out_writable(out_req.sel)) begin
            req_tog <= ~req_tog;
            hold    <= out_req;
        end
    end

    cfgmb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(in_clk), .rst(rst), .d(req_tog), .q(req_s)
    );

    always_ff @(posedge in_clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= req_s;
    end

    cfgmb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(out_clk), .rst(rst), .d(seen), .q(ack_s)
    );

    assign apply     = req_s ^ seen;
    assign apply_req = hold;
endmodule

// File: rtl/cfgmb_mailbox.sv
module cfgmb_mailbox
    import cfgmb_pkg::*;
(
    input  logic              in_clk,
    input  logic              out_clk,
    input  logic              rst,
    input  logic              put,
    input  logic [DATA_W-1:0] put_data,
    input  logic              take,
    output logic              full,
    output logic              ready,
    output logic [DATA_W-1:0] word
);
    logic put_tog, take_tog, put_s, take_s, take_seen;

    always_ff @(posedge in_clk) begin
        if (rst) begin
            full      <= 1'b0;
            put_tog   <= 1'b0;
            take_seen <= 1'b0;
            word      <= '0;
        end else begin
            take_seen <= take_s;
            if (put && !full) begin
                word    <= put_data;
                put_tog <= ~put_tog;
                full    <= 1'b1;
            end else if (take_s ^ take_seen) begin
                full <= 1'b0;
            end
        end
    end

    cfgmb_sync #(.STAGES(SYNC_STAGES)) u_put_sync (
        .clk(out_clk), .rst(rst), .d(put_tog), .q(put_s)
    );

    assign ready = put_s ^ take_tog;

    always_ff @(posedge out_clk) begin
        if (rst)                take_tog <= 1'b0;
        else if (take && ready) take_tog <= ~take_tog;
    end

    cfgmb_sync #(.STAGES(SYNC_STAGES)) u_take_sync (
        .clk(in_clk), .rst(rst), .d(take_tog), .q(take_s)
    );
endmodule

// File: rtl/cfgmb_rdport.sv
module cfgmb_rdport
    import cfgmb_pkg::*;
(
    input  logic              out_clk,
    input  logic              rst,
    input  logic              rd,
    input  sel_e              sel,
    input  logic              blocked,
    input  cfg_t              cfg,
    input  logic [DATA_W-1:0] mail,
    output logic              mail_take,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic              grant;
    logic [DATA_W-1:0] pick;

    assign grant     = rd && !blocked && (sel != SEL_NONE);
    assign mail_take = grant && (sel == SEL_MAIL);

    always_comb begin
        case (sel)
            SEL_RT_BASE: pick = widen_ptr(cfg.rt_base);
            SEL_RT_OFFS: pick = widen_ptr(cfg.rt_offs);
            SEL_AF_THR:  pick = widen_ptr(cfg.af_thr);
            SEL_PARITY:  pick = {{(DATA_W-PAR_W){1'b0}}, cfg.parity};
            SEL_AE_THR:  pick = widen_ptr(cfg.ae_thr);
            SEL_CTRL:    pick = {{(DATA_W-CTRL_W){1'b0}}, cfg.ctrl};
            SEL_MAIL:    pick = mail;
            default:     pick = '0;
        endcase
    end

    always_ff @(posedge out_clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= grant;
            rd_data  <= grant ? pick : '0;
        end
    end
endmodule

// File: rtl/cfgmb_top.sv
module cfgmb_top
    import cfgmb_pkg::*;
(
    input  logic              in_clk,
    input  logic              out_clk,
    input  logic              rst,
    input  logic              in_wr,
    input  logic [SEL_W-1:0]  in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              out_rd,
    input  logic              out_wr,
    input  logic [SEL_W-1:0]  out_addr,
    input  logic [DATA_W-1:0] out_wdata,
    input  logic              fifo_path_on,
    input  logic              bypass_on,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mb_full_n,
    output logic              mb_ready,
    output logic [PTR_W-1:0]  rt_base,
    output logic [PTR_W-1:0]  rt_offs,
    output logic [PTR_W-1:0]  af_ofs,
    output logic [PTR_W-1:0]  ae_ofs,
    output logic [PAR_W-1:0]  parity_cfg,
    output logic              af_sync_mode,
    output logic [1:0]        hf_mode
);
    cfg_t              cfg_q, cfg_d;
    logic              xw_apply;
    wr_req_t           xw_req;
    logic [DATA_W-1:0] mb_word;
    logic              mb_full, mb_take;
    sel_e              in_sel;

    assign in_sel = sel_e'(in_addr);

    cfgmb_xwrite u_xwrite (
        .in_clk    (in_clk),
        .out_clk   (out_clk),
        .rst       (rst),
        .out_wr    (out_wr),
        .out_req   ('{sel: sel_e'(out_addr), data: out_wdata}),
        .apply     (xw_apply),
        .apply_req (xw_req)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (xw_apply) cfg_d = cfg_put(cfg_d, xw_req.sel, xw_req.data);
        if (in_wr)    cfg_d = cfg_put(cfg_d, in_sel, in_data);
    end

    always_ff @(posedge in_clk) begin
        if (rst) cfg_q <= CFG_RST;
        else     cfg_q <= cfg_d;
    end

    cfgmb_mailbox u_mbox (
        .in_clk   (in_clk),
        .out_clk  (out_clk),
        .rst      (rst),
        .put      (in_wr && (in_sel == SEL_MAIL)),
        .put_data (in_data),
        .take     (mb_take),
        .full     (mb_full),
        .ready    (mb_ready),
        .word     (mb_word)
    );

    cfgmb_rdport u_rdport (
        .out_clk   (out_clk),
        .rst       (rst),
        .rd        (out_rd),
        .sel       (sel_e'(out_addr)),
        .blocked   (fifo_path_on || bypass_on),
        .cfg       (cfg_q),
        .mail      (mb_word),
        .mail_take (mb_take),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign mb_full_n    = ~mb_full;
    assign rt_base      = cfg_q.rt_base;
    assign rt_offs      = cfg_q.rt_offs;
    assign af_ofs       = cfg_q.af_thr;
    assign ae_ofs       = cfg_q.ae_thr;
    assign parity_cfg   = cfg_q.parity;
    assign af_sync_mode = cfg_q.ctrl[AF_MODE_BIT];
    assign hf_mode      = cfg_q.ctrl[HF_MODE_LSB+1:HF_MODE_LSB];
endmodule

// File: rtl/cfgmb_chk.sv
module cfgmb_chk
    import cfgmb_pkg::*;
(
    input logic              in_clk,
    input logic              out_clk,
    input logic              rst,
    input logic              in_wr,
    input logic [SEL_W-1:0]  in_addr,
    input logic [DATA_W-1:0] in_data,
    input logic              out_rd,
    input logic [SEL_W-1:0]  out_addr,
    input logic              fifo_path_on,
    input logic              bypass_on,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              mb_full_n,
    input logic [PTR_W-1:0]  af_ofs,
    input logic [PTR_W-1:0]  ae_ofs,
    input logic              xw_apply,
    input wr_req_t           xw_req,
    input logic [DATA_W-1:0] mb_word
);
    AST_MB_SET: assert property (@(posedge in_clk) disable iff (rst)
        (in_wr && in_addr == 3'd6 && mb_full_n) |=> !mb_full_n); // R6

    AST_MB_KEEP: assert property (@(posedge in_clk) disable iff (rst)
        (in_wr && in_addr == 3'd6 && !mb_full_n) |=> $stable(mb_word)); // R7

    AST_IN_WINS: assert property (@(posedge in_clk) disable iff (rst)
        (xw_apply && in_wr && in_addr == 3'd2 && xw_req.sel == SEL_AF_THR)
        |=> af_ofs == $past(in_data[PTR_W-1:0])); // R11

    AST_THR_HOLD: assert property (@(posedge in_clk) disable iff (rst)
        (!in_wr && !xw_apply) |=> ($stable(af_ofs) && $stable(ae_ofs))); // R4

    AST_RD_GATE: assert property (@(posedge out_clk) disable iff (rst)
        (out_rd && (fifo_path_on || bypass_on)) |=> (!rd_valid && rd_data == '0)); // R3

    AST_RD_DUE: assert property (@(posedge out_clk) disable iff (rst)
        (out_rd && !fifo_path_on && !bypass_on && out_addr != 3'd7) |=> rd_valid); // R2
endmodule

bind cfgmb_top cfgmb_chk u_chk (
    .in_clk(in_clk), .out_clk(out_clk), .rst(rst),
    .in_wr(in_wr), .in_addr(in_addr), .in_data(in_data),
    .out_rd(out_rd), .out_addr(out_addr),
    .fifo_path_on(fifo_path_on), .bypass_on(bypass_on),
    .rd_valid(rd_valid), .rd_data(rd_data), .mb_full_n(mb_full_n),
    .af_ofs(af_ofs), .ae_ofs(ae_ofs),
    .xw_apply(xw_apply), .xw_req(xw_req), .mb_word(mb_word)
);

// File: tb/cfgmb_top_tb.sv
module cfgmb_top_tb;
    logic        in_clk = 1'b0, out_clk = 1'b0, rst = 1'b1;
    logic        in_wr = 1'b0, out_rd = 1'b0, out_wr = 1'b0;
    logic [2:0]  in_addr = '0, out_addr = '0;
    logic [35:0] in_data = '0, out_wdata = '0;
    logic        fifo_path_on = 1'b0, bypass_on = 1'b0;
    logic        rd_valid, mb_full_n, mb_ready, af_sync_mode;
    logic [35:0] rd_data;
    logic [9:0]  rt_base, rt_offs, af_ofs, ae_ofs;
    logic [3:0]  parity_cfg;
    logic [1:0]  hf_mode;

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [35:0] exp_q[$];
    string       tag_q[$];

    always #4 in_clk = ~in_clk;
    always #5.5 out_clk = ~out_clk;

    cfgmb_top u_dut (
        .in_clk(in_clk), .out_clk(out_clk), .rst(rst),
        .in_wr(in_wr), .in_addr(in_addr), .in_data(in_data),
        .out_rd(out_rd), .out_wr(out_wr), .out_addr(out_addr), .out_wdata(out_wdata),
        .fifo_path_on(fifo_path_on), .bypass_on(bypass_on),
        .rd_valid(rd_valid), .rd_data(rd_data), .mb_full_n(mb_full_n), .mb_ready(mb_ready),
        .rt_base(rt_base), .rt_offs(rt_offs), .af_ofs(af_ofs), .ae_ofs(ae_ofs),
        .parity_cfg(parity_cfg), .af_sync_mode(af_sync_mode), .hf_mode(hf_mode)
    );

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected word per valid read result
    always @(negedge out_clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected", rd_data, '0);
            end else begin
                automatic logic [35:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rd_data === e, t, rd_data, e);
            end
        end
    end

    task automatic in_cyc(input int n);
        repeat (n) @(negedge in_clk);
    endtask

    task automatic out_cyc(input int n);
        repeat (n) @(negedge out_clk);
    endtask

    task automatic in_write(input logic [2:0] a, input logic [35:0] d);
        @(negedge in_clk);
        in_wr = 1'b1; in_addr = a; in_data = d;
        @(negedge in_clk);
        in_wr = 1'b0;
    endtask

    task automatic out_write(input logic [2:0] a, input logic [35:0] d);
        @(negedge out_clk);
        out_wr = 1'b1; out_addr = a; out_wdata = d;
        @(negedge out_clk);
        out_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [35:0] e, input string t);
        @(negedge out_clk);
        out_rd = 1'b1; out_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge out_clk);
        out_rd = 1'b0;
        out_cyc(1);
    endtask

    task automatic rd_refused(input logic [2:0] a, input bit fp, input bit bp, input string t);
        @(negedge out_clk);
        out_rd = 1'b1; out_addr = a; fifo_path_on = fp; bypass_on = bp;
        @(negedge out_clk);
        out_rd = 1'b0; fifo_path_on = 1'b0; bypass_on = 1'b0;
        chk(rd_valid == 1'b0 && rd_data == '0, t, {35'd0, rd_valid}, '0);
    endtask

    task automatic wait_thr(input bit use_af, input logic [9:0] v, input string t);
        int k;
        k = 0;
        while (((use_af ? af_ofs : ae_ofs) != v) && k < 12) begin
            in_cyc(1); k++;
        end
        chk((use_af ? af_ofs : ae_ofs) == v, t, {26'd0, (use_af ? af_ofs : ae_ofs)}, {26'd0, v});
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k;
        in_cyc(20);
        rst = 1'b0;
        in_cyc(2);

        // R1 reset values through the read port
        rd_expect(3'd0, 36'd0, "R1 rt_base");
        rd_expect(3'd1, 36'd0, "R1 rt_offs");
        rd_expect(3'd2, 36'd8, "R1 af_thr");
        rd_expect(3'd3, 36'd0, "R1 parity");
        rd_expect(3'd4, 36'd8, "R1 ae_thr");
        rd_expect(3'd5, 36'd1, "R1 ctrl");
        rd_expect(3'd6, 36'd0, "R1 mailbox");
        chk(mb_full_n == 1'b1, "R1 mb_full_n", {35'd0, mb_full_n}, 36'd1);
        chk(af_sync_mode == 1'b0 && hf_mode == 2'd0, "R5 reset modes", {33'd0, af_sync_mode, hf_mode}, '0);

        // R4 input-port writes, upper bits dropped
        in_write(3'd0, 36'hF_0000_0155);
        in_write(3'd1, 36'h0_0000_02AA);
        in_write(3'd2, 36'h0_0000_03F0);
        in_write(3'd3, 36'h0_0000_00FA);
        in_write(3'd4, 36'h0_0000_0011);
        in_write(3'd5, 36'h0_0000_0138);
        chk(rt_base == 10'h155 && ae_ofs == 10'h011, "R4 outputs", {16'd0, rt_base, ae_ofs}, {16'd0, 10'h155, 10'h011});
        chk(af_sync_mode == 1'b1 && hf_mode == 2'd3, "R5 ctrl 0x38", {33'd0, af_sync_mode, hf_mode}, 36'd7);
        in_write(3'd7, 36'h0_0000_0000);
        rd_expect(3'd0, 36'h155, "R2 rt_base");
        rd_expect(3'd1, 36'h2AA, "R2 rt_offs");
        rd_expect(3'd2, 36'h3F0, "R2 af_thr");
        rd_expect(3'd3, 36'h00A, "R2 parity");
        rd_expect(3'd4, 36'h011, "R4 sel7 no effect");
        rd_expect(3'd5, 36'h038, "R2 ctrl");
        in_write(3'd5, 36'h0_0000_0010);
        chk(af_sync_mode == 1'b0 && hf_mode == 2'd2, "R5 ctrl 0x10", {33'd0, af_sync_mode, hf_mode}, 36'd2);

        // R3 refused reads
        rd_refused(3'd2, 1'b1, 1'b0, "R3 fifo path on");
        rd_refused(3'd2, 1'b0, 1'b1, "R3 bypass on");
        rd_refused(3'd7, 1'b0, 1'b0, "R3 selector 7");

        // R6 / R7 mailbox write and overwrite attempt
        in_write(3'd6, 36'h9_8765_4321);
        chk(mb_full_n == 1'b0, "R6 full after write", {35'd0, mb_full_n}, '0);
        in_write(3'd6, 36'h0_0000_0001);
        k = 0;
        while (!mb_ready && k < 10) begin out_cyc(1); k++; end
        chk(mb_ready == 1'b1, "R8 ready", {35'd0, mb_ready}, 36'd1);
        rd_expect(3'd6, 36'h9_8765_4321, "R7 mail kept");
        k = 0;
        while (!mb_full_n && k < 10) begin in_cyc(1); k++; end
        chk(mb_full_n == 1'b1 && k <= 6, "R8 full clears", {35'd0, mb_full_n}, 36'd1);
        out_cyc(4);
        chk(mb_ready == 1'b0, "R8 ready drops", {35'd0, mb_ready}, '0);
        rd_expect(3'd6, 36'h9_8765_4321, "R8 read without mail");
        in_cyc(6);
        chk(mb_full_n == 1'b1, "R8 empty read no effect", {35'd0, mb_full_n}, 36'd1);
        in_write(3'd6, 36'h0_ABCD_0123);
        chk(mb_full_n == 1'b0, "R6 second mail", {35'd0, mb_full_n}, '0);
        k = 0;
        while (!mb_ready && k < 10) begin out_cyc(1); k++; end
        rd_expect(3'd6, 36'h0_ABCD_0123, "R8 second mail");
        in_cyc(8);

        // R9 output-port writes
        out_write(3'd2, 36'h123);
        wait_thr(1'b1, 10'h123, "R9 af from out port");
        rd_expect(3'd2, 36'h123, "R9 af readback");
        out_cyc(6);
        out_write(3'd5, 36'h3F);
        out_cyc(10);
        chk(hf_mode == 2'd2 && af_sync_mode == 1'b0, "R9 ctrl not writable", {34'd0, hf_mode}, 36'd2);
        out_write(3'd6, 36'h777);
        in_cyc(10);
        chk(mb_full_n == 1'b1, "R9 mail not writable", {35'd0, mb_full_n}, 36'd1);
        out_write(3'd0, 36'h0AB);
        in_cyc(10);
        chk(rt_base == 10'h0AB, "R9 base from out port", {26'd0, rt_base}, 36'h0AB);

        // R10 back-to-back: second write dropped
        @(negedge out_clk);
        out_wr = 1'b1; out_addr = 3'd4; out_wdata = 36'h044;
        @(negedge out_clk);
        out_wdata = 36'h055;
        @(negedge out_clk);
        out_wr = 1'b0;
        in_cyc(16);
        chk(ae_ofs == 10'h044, "R10 second dropped", {26'd0, ae_ofs}, 36'h044);

        // R11 conflict: input write held across the output write arrival
        @(negedge in_clk);
        in_wr = 1'b1; in_addr = 3'd4; in_data = 36'h077;
        fork
            out_write(3'd4, 36'h0EE);
            begin
                for (int i = 0; i < 20; i++) begin
                    @(negedge in_clk);
                    if (ae_ofs == 10'h0EE) chk(1'b0, "R11 out value visible", {26'd0, ae_ofs}, 36'h077);
                end
            end
        join
        in_wr = 1'b0;
        in_cyc(2);
        chk(ae_ofs == 10'h077, "R11 input wins", {26'd0, ae_ofs}, 36'h077);

        out_cyc(4);
        chk(exp_q.size() == 0, "R2 all reads returned", 36'(exp_q.size()), '0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule